// File: doc/BRIEF.md
# Prioritised Interrupt Request Register

This block gathers four external interrupt request lines into one byte-wide register. The low half records which sources are pending. The high half holds one enable bit per source. A request line must stay high for a minimum number of clock edges before it counts as a request. Once captured, the pending bit stays set after the line drops.

When the core signals an instruction boundary and some enabled source is pending, the block issues a one-cycle strobe with a vector address for the program sequencer. Source 0 has its own vector, address 1. Sources 1 to 3 share address 2. Source 0 always wins over the others.

Software reads the byte back and writes it through one port. Writing a 0 into a pending position is the acknowledge. Writing 1 to a pending position changes nothing. A source that has been vectored is not vectored again until its pending bit has been cleared and then captured anew.

Top module: `irq_request_reg`

## Requirements
- R1: A synchronous active-high `rst` clears every pending bit, every enable bit, `take_irq` and `vec_addr` to 0, so `rd_data` reads 0 after the reset edge.
- R2: A request on `irq_in[i]` sets pending bit i only when the line is high at two consecutive rising edges. The bit is visible in `rd_data[i]` right after the second edge. A line that is high for one edge only never sets it.
- R3: A pending bit stays set after its request line drops. A write with `wr_data[i]`=0 clears it. A write with `wr_data[i]`=1 leaves it unchanged and never sets it.
- R4: A write loads `wr_data[4+i]` as the enable bit for source i (bits 7:4). `rd_data` reads back {enables[3:0], pending[3:0]}.
- R5: If a qualified request and a clearing write reach the same bit at the same edge, the capture wins and the bit stays set.
- R6: `take_irq` is high for exactly the cycle after a rising edge where `at_boundary` was high and at least one source was pending, enabled and not yet vectored. There is no strobe without `at_boundary`.
- R7: When source 0 is eligible, the strobe carries `vec_addr`=1. When only sources 1 to 3 are eligible, it carries `vec_addr`=2. If both apply, address 1 is issued first and address 2 at the next boundary.
- R8: A vectored source is not vectored again until its pending bit has been cleared and captured anew. One strobe to address 2 covers every source among 1 to 3 that was eligible at that edge.
- R9: A pending source whose enable bit is 0 never causes a strobe. Setting its enable later, without clearing it, causes a strobe at the next boundary.
- R10: `vec_addr` keeps its last issued value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 4 | External request lines, one per source |
| wr_en | input | 1 | Byte write strobe for the register |
| wr_data | input | 8 | Write data: enables in 7:4, pending mask in 3:0 |
| rd_data | output | 8 | Read-back: enables in 7:4, pending in 3:0 |
| at_boundary | input | 1 | Core is at an instruction boundary |
| take_irq | output | 1 | One-cycle strobe: redirect the sequencer |
| vec_addr | output | 12 | Vector target issued with the strobe |

## Verification
The bench sweeps all 256 pairs of enable mask and request pattern. For each pair it predicts the strobe and the vector from the masks. A design that inverted the priority would send source 0 to address 2 whenever a shared source was also pending. A design that forgot the served state would issue the same vector again at every boundary while `at_boundary` stays high.

Directed cases cover the remaining corners:
- A one-edge glitch must leave nothing pending. A filter that is one stage short would latch it.
- A write of ones must not set pending bits. A plain register load would create requests.
- A clearing write that collides with a live request must lose, or an edge would be dropped.
- A late enable must still deliver the waiting request.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_SRC      = 4;
  localparam int IRQ_ADDR_W   = 12;
  localparam int IRQ_MIN_HOLD = 2;
  localparam int IRQ_VEC_PRI  = 1;
  localparam int IRQ_VEC_SHR  = 2;
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int N        = 4,
  parameter int MIN_HOLD = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_in,
  output logic [N-1:0] qual
);
  localparam int CW = (MIN_HOLD > 1) ? $clog2(MIN_HOLD) : 1;

  for (genvar i = 0; i < N; i++) begin : g_src
    if (MIN_HOLD <= 1) begin : g_direct
      assign qual[i] = irq_in[i];
    end else begin : g_count
      localparam logic [CW-1:0] LIM = CW'(MIN_HOLD - 1);
      logic [CW-1:0] run_q;
      always_ff @(posedge clk) begin
        if (rst)              run_q <= '0;
        else if (!irq_in[i])  run_q <= '0;
        else if (run_q != LIM) run_q <= run_q + 1'b1;
      end
      assign qual[i] = irq_in[i] && (run_q == LIM);
    end
  end
endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   qual,
  input  logic           wr_en,
  input  logic [2*N-1:0] wr_data,
  output logic [N-1:0]   pend_q,
  output logic [N-1:0]   en_q
);
  logic [N-1:0] pend_d;
  logic [N-1:0] en_d;

  always_comb begin
    pend_d = pend_q | qual;
    en_d   = en_q;
    if (wr_en) begin
      pend_d = (pend_q & wr_data[N-1:0]) | qual;
      en_d   = wr_data[2*N-1:N];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (pend_q[i] && !(wr_en && !wr_data[i])) |=> pend_q[i]);
    p_noset_r3: assert property (@(posedge clk) disable iff (rst)
      (!pend_q[i] && !qual[i]) |=> !pend_q[i]);
    p_capture_wins_r5: assert property (@(posedge clk) disable iff (rst)
      qual[i] |=> pend_q[i]);
  end

  p_en_load_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (en_q == $past(wr_data[2*N-1:N])));
endmodule

// File: rtl/irq_vector_arb.sv
module irq_vector_arb #(
  parameter int N       = 4,
  parameter int ADDR_W  = 12,
  parameter int VEC_PRI = 1,
  parameter int VEC_SHR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              at_boundary,
  input  logic [N-1:0]      pend,
  input  logic [N-1:0]      en,
  output logic              take_o,
  output logic [ADDR_W-1:0] vec_o
);
  localparam logic [ADDR_W-1:0] A_PRI = ADDR_W'(VEC_PRI);
  localparam logic [ADDR_W-1:0] A_SHR = ADDR_W'(VEC_SHR);

  logic [N-1:0]      served_q;
  logic [N-1:0]      elig;
  logic [N-1:0]      grant;
  logic [ADDR_W-1:0] vec_sel;

  assign elig = pend & en & ~served_q;

  always_comb begin
    grant   = '0;
    vec_sel = vec_o;
    if (at_boundary) begin
      if (elig[0]) begin
        grant[0] = 1'b1;
        vec_sel  = A_PRI;
      end else if (|(elig >> 1)) begin
        grant   = elig & ~N'(1);
        vec_sel = A_SHR;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      served_q <= '0;
      take_o   <= 1'b0;
      vec_o    <= '0;
    end else begin
      served_q <= (served_q & pend) | grant;
      take_o   <= |grant;
      vec_o    <= vec_sel;
    end
  end

  p_gate_r6: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(at_boundary));
  p_vec_range_r7: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (vec_o == A_PRI || vec_o == A_SHR));
  p_pri_first_r7: assert property (@(posedge clk) disable iff (rst)
    (at_boundary && pend[0] && en[0] && !served_q[0]) |=> (take_o && vec_o == A_PRI));
  p_no_repeat_r8: assert property (@(posedge clk) disable iff (rst)
    (take_o && vec_o == A_PRI) |=> !(take_o && vec_o == A_PRI));
  p_enabled_r9: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(|(pend & en)));
  p_vec_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !take_o |-> $stable(vec_o));
endmodule

// File: rtl/irq_request_reg.sv
module irq_request_reg
  import irq_pkg::*;
#(
  parameter int N        = IRQ_SRC,
  parameter int ADDR_W   = IRQ_ADDR_W,
  parameter int MIN_HOLD = IRQ_MIN_HOLD,
  parameter int VEC_PRI  = IRQ_VEC_PRI,
  parameter int VEC_SHR  = IRQ_VEC_SHR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      irq_in,
  input  logic              wr_en,
  input  logic [2*N-1:0]    wr_data,
  output logic [2*N-1:0]    rd_data,
  input  logic              at_boundary,
  output logic              take_irq,
  output logic [ADDR_W-1:0] vec_addr
);
  logic [N-1:0] qual;
  logic [N-1:0] pend_q;
  logic [N-1:0] en_q;

  irq_qualify #(.N(N), .MIN_HOLD(MIN_HOLD)) u_qual (
    .clk(clk), .rst(rst), .irq_in(irq_in), .qual(qual)
  );

  irq_reg_bank #(.N(N)) u_bank (
    .clk(clk), .rst(rst), .qual(qual), .wr_en(wr_en), .wr_data(wr_data),
    .pend_q(pend_q), .en_q(en_q)
  );

  irq_vector_arb #(.N(N), .ADDR_W(ADDR_W), .VEC_PRI(VEC_PRI), .VEC_SHR(VEC_SHR)) u_arb (
    .clk(clk), .rst(rst), .at_boundary(at_boundary), .pend(pend_q), .en(en_q),
    .take_o(take_irq), .vec_o(vec_addr)
  );

  assign rd_data = {en_q, pend_q};

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !take_irq && vec_addr == '0));

  for (genvar i = 0; i < N; i++) begin : g_rise
    p_rise_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(pend_q[i]) |-> $past(irq_in[i]));
  end
endmodule

// File: tb/test_irq_request_reg.sv
module test_irq_request_reg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  irq_in = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        at_boundary = 1'b0;
  logic        take_irq;
  logic [11:0] vec_addr;

  int total = 0;
  int bad = 0;
  int last_vec = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_request_reg i_irq_request_reg (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .at_boundary(at_boundary), .take_irq(take_irq),
    .vec_addr(vec_addr)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step(); step();
    rst = 1'b0;
    chk(rd_data == 8'h00, "R1 reset rd_data", rd_data, 0);
    chk(take_irq == 1'b0, "R1 reset take", take_irq, 0);
    chk(vec_addr == 12'd0, "R1 reset vec", vec_addr, 0);

    for (int en = 0; en < 16; en++) begin
      for (int rq = 0; rq < 16; rq++) begin
        logic [3:0] el;
        wr({en[3:0], 4'h0});
        step(); step();
        irq_in = rq[3:0];
        step(); step();
        irq_in = 4'h0;
        step();
        chk(rd_data == {en[3:0], rq[3:0]}, "R2 R3 R4 readback", rd_data, {en[3:0], rq[3:0]});
        chk(take_irq == 1'b0, "R6 no strobe without boundary", take_irq, 0);
        el = en[3:0] & rq[3:0];
        at_boundary = 1'b1;
        step();
        if (el != 0) begin
          int ev;
          ev = el[0] ? 1 : 2;
          chk(take_irq && vec_addr == 12'(ev), "R7 first vector", vec_addr, ev);
          last_vec = ev;
        end else begin
          chk(!take_irq, "R9 disabled gives no strobe", take_irq, 0);
          chk(vec_addr == 12'(last_vec), "R10 vector held", vec_addr, last_vec);
        end
        step();
        if (el[0] && (el[3:1] != 0)) begin
          chk(take_irq && vec_addr == 12'd2, "R7 shared after primary", vec_addr, 2);
          last_vec = 2;
        end else begin
          chk(!take_irq, "R8 no repeat", take_irq, 0);
        end
        step();
        chk(!take_irq, "R8 no repeat later", take_irq, 0);
        at_boundary = 1'b0;
      end
    end

    wr(8'h00); step(); step();
    irq_in = 4'b0100; step(); irq_in = 4'h0; step(); step();
    chk(rd_data[3:0] == 4'h0, "R2 single edge ignored", rd_data[3:0], 0);

    wr(8'h0F); step();
    chk(rd_data == 8'h00, "R3 write one does not set", rd_data, 0);

    irq_in = 4'b1010; step(); step(); irq_in = 4'h0; step();
    wr(8'h08);
    chk(rd_data == 8'h08, "R3 partial clear", rd_data, 8'h08);

    wr(8'h00); step();
    irq_in = 4'b0010; step(); step();
    wr(8'h00);
    chk(rd_data[1] == 1'b1, "R5 capture beats clear", rd_data[1], 1);
    irq_in = 4'h0; step();
    wr(8'h00); step(); step();
    chk(rd_data == 8'h00, "R3 cleared after collision", rd_data, 0);

    irq_in = 4'b0001; step(); step(); irq_in = 4'h0;
    at_boundary = 1'b1; step(); at_boundary = 1'b0;
    chk(!take_irq, "R9 pending but disabled", take_irq, 0);
    wr(8'h11);
    at_boundary = 1'b1; step(); at_boundary = 1'b0;
    chk(take_irq && vec_addr == 12'd1, "R9 late enable", vec_addr, 1);
    step();
    chk(!take_irq, "R6 strobe one cycle", take_irq, 0);

    wr(8'h10); step(); step();
    irq_in = 4'b0001; step(); step(); irq_in = 4'h0;
    at_boundary = 1'b1; step(); at_boundary = 1'b0;
    chk(take_irq && vec_addr == 12'd1, "R8 reissue after clear", vec_addr, 1);

    irq_in = 4'b1111; step(); step();
    wr(8'hF0);
    rst = 1'b1; step(); step(); rst = 1'b0; irq_in = 4'h0;
    chk(rd_data == 8'h00 && !take_irq && vec_addr == 12'd0, "R1 reset mid run", rd_data, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule